// File: doc/BRIEF.md
# Flash Write-Buffer Command Sequencer

This block is the command front end of a NOR-style flash model. It watches the write cycles on the bus (word address, data, write strobe) and recognises the buffered-programming dialogue. The host first sends two unlock cycles and a buffer-load command at the target sector. It then writes the word count as N-1 and loads N address/data pairs that climb one by one inside a single 32-word page. A confirm command at the same sector ends the dialogue. The words go into an internal page buffer. The block then raises one program request towards the array and holds it until the array answers done. While the request is up, the array reads the buffer through a side port.

Any breach of the dialogue moves the block into a sticky abort state. Examples are a count larger than the buffer, a pair out of sequence or outside the page, a cycle in the wrong sector, a bad confirm code, or a program attempt while the lock input is low. An unlock-bypass mode removes the two unlock cycles from every command. In that mode a single word program takes only a program command and a data write. An abort raised in bypass mode is cleared only by the full three-cycle reset sequence. A single reset write is enough to clear an abort in normal mode.

The states are IDLE, UNLK1 and UNLK2 (unlock progress), BYPASS (bypass home state), COUNT (waiting for N-1), LOAD_FIRST, LOAD, CONFIRM, PROG (single word), BUSY (request outstanding), and ABORT, ABT_U1 and ABT_U2 (abort and full-reset progress). The transitions are as follows:
- IDLE goes to UNLK1 on the first unlock cycle.
- UNLK1 goes to UNLK2 on the second unlock cycle, and falls back to IDLE on anything else.
- UNLK2 goes to COUNT on the load command, to BYPASS on the bypass command, and to PROG on the program command.
- BYPASS goes to COUNT on the load command and to PROG on the program command. A reset write returns it to IDLE.
- COUNT goes to LOAD_FIRST, and LOAD_FIRST goes to LOAD or CONFIRM.
- CONFIRM and PROG go to BUSY, which returns home on done.
- Any violation goes to ABORT. A reset write in normal mode returns ABORT to IDLE. The full reset sequence goes from ABORT through ABT_U1 and ABT_U2 back home.

Top module: `wbuf_cmd_seq`

## Requirements
- R1: After reset, arr_req, abort and bypass are all 0.
- R2: The normal dialogue loads N words and then raises arr_req: data AAh at word address low bits 555h, 55h at 2AAh, 25h at sector S, count N-1 at S, N pairs, and 29h at S. At that point arr_addr is the first loaded address, arr_last is N-1, and arr_rd_data at index addr[4:0] returns each loaded word. The sector is addr[21:15] and the page is addr[21:5].
- R3: A count value above 31 (for example 20h) raises abort. A count of 1Fh is accepted and programs 32 words.
- R4: Abort is raised, and no request follows, when a pair after the first has an address other than the previous address plus one, or when it leaves the page of the first pair.
- R5: Abort is raised when the count write, the first pair or the confirm lies outside the sector of the load command, or when the confirm data is not 29h.
- R6: arr_req stays high, with arr_addr and arr_last stable, until arr_done is seen. Bus writes made while arr_req is high have no effect. One cycle after arr_done, arr_req is 0.
- R7: When lock_n is 0 at the confirm or single-program data cycle, abort is raised and arr_req stays 0.
- R8: The unlock cycles followed by 20h set bypass. In bypass, A0h followed by one data write programs that single word (arr_last 0). Buffer loads are then accepted without unlock cycles.
- R9: In normal mode, abort stays set across idle cycles. A single write of F0h clears it.
- R10: In bypass mode, a single F0h write does not clear abort. The sequence AAh@555h, 55h@2AAh, F0h clears it and returns to bypass.
- R11: In bypass mode with no abort, a write of F0h leaves bypass. After that, A0h without unlock cycles is ignored.
- R12: A broken unlock (wrong second cycle) returns to idle. The command, count, data and confirm writes that follow raise neither abort nor arr_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per bus write |
| bus_addr | input | ADDR_W (22) | Word address of the write |
| bus_data | input | DATA_W (16) | Write data |
| lock_n | input | 1 | Low keeps every sector locked |
| arr_done | input | 1 | Array finished the requested program |
| arr_rd_idx | input | 5 | Buffer index read by the array |
| arr_req | output | 1 | Program request to the array; also the busy flag |
| arr_addr | output | ADDR_W (22) | First word address to program |
| arr_last | output | 5 | Number of words to program minus one |
| arr_rd_data | output | DATA_W (16) | Buffer word at arr_rd_idx |
| abort | output | 1 | Sticky sequence-violation flag |
| bypass | output | 1 | Unlock-bypass mode active |

## Verification
The assertions check several rules on every cycle. A request holds with a stable address and length until done, and it never coexists with abort. A request only starts after a bus write, and only with the lock input high. Abort and bypass never change without a bus write. Data integrity through the buffer, the count limit, the page and sequence rules, the sector and confirm checks, and the different reset rules in normal and bypass mode all depend on whole command dialogues, so only the directed scenarios can show them.

// File: rtl/wbuf_cmd_pkg.sv
package wbuf_cmd_pkg;

    localparam logic [10:0] UNLK_ADDR_A = 11'h555;
    localparam logic [10:0] UNLK_ADDR_B = 11'h2AA;
    localparam logic [7:0]  UNLK_DATA_A = 8'hAA;
    localparam logic [7:0]  UNLK_DATA_B = 8'h55;
    localparam logic [7:0]  OP_LOAD     = 8'h25;
    localparam logic [7:0]  OP_CONFIRM  = 8'h29;
    localparam logic [7:0]  OP_BYPASS   = 8'h20;
    localparam logic [7:0]  OP_PROG     = 8'hA0;
    localparam logic [7:0]  OP_RESET    = 8'hF0;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_LOAD,
        CMD_CONFIRM,
        CMD_BYPASS,
        CMD_PROG,
        CMD_RESET,
        CMD_OTHER
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNLK1,
        ST_UNLK2,
        ST_BYPASS,
        ST_COUNT,
        ST_LOAD_FIRST,
        ST_LOAD,
        ST_CONFIRM,
        ST_PROG,
        ST_BUSY,
        ST_ABORT,
        ST_ABT_U1,
        ST_ABT_U2
    } seq_state_e;

endpackage

// File: rtl/wbuf_cmd_decode.sv
module wbuf_cmd_decode
    import wbuf_cmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              bus_we,
    input  logic [10:0]       cmd_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              is_unlk1,
    output logic              is_unlk2,
    output cmd_kind_e         cmd
);

    always_comb begin
        is_unlk1 = bus_we && (cmd_addr == UNLK_ADDR_A) && (bus_data == DATA_W'(UNLK_DATA_A));
        is_unlk2 = bus_we && (cmd_addr == UNLK_ADDR_B) && (bus_data == DATA_W'(UNLK_DATA_B));
        if (!bus_we) begin
            cmd = CMD_NONE;
        end else if (bus_data == DATA_W'(OP_LOAD)) begin
            cmd = CMD_LOAD;
        end else if (bus_data == DATA_W'(OP_CONFIRM)) begin
            cmd = CMD_CONFIRM;
        end else if (bus_data == DATA_W'(OP_BYPASS)) begin
            cmd = CMD_BYPASS;
        end else if (bus_data == DATA_W'(OP_PROG)) begin
            cmd = CMD_PROG;
        end else if (bus_data == DATA_W'(OP_RESET)) begin
            cmd = CMD_RESET;
        end else begin
            cmd = CMD_OTHER;
        end
    end

endmodule

// File: rtl/wbuf_page_ram.sv
module wbuf_page_ram #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/wbuf_seq_fsm.sv
module wbuf_seq_fsm
    import wbuf_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int BUF_WORDS = 32,
    parameter int SECT_LSB  = 15,
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              is_unlk1,
    input  logic              is_unlk2,
    input  cmd_kind_e         cmd,
    input  logic              lock_n,
    input  logic              arr_done,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_idx,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [IDX_W-1:0]  arr_last,
    output logic              abort,
    output logic              bypass
);

    localparam int SECT_W = ADDR_W - SECT_LSB;
    localparam int PAGE_W = ADDR_W - IDX_W;

    seq_state_e        state_q, state_d, home;
    logic [SECT_W-1:0] sect_q;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] next_q;
    logic [ADDR_W-1:0] start_q;
    logic [IDX_W-1:0]  remain_q;
    logic [IDX_W-1:0]  last_q;
    logic              bypass_q;
    logic              sect_hit, page_hit, seq_hit, count_ok;

    always_comb begin
        sect_hit = bus_addr[ADDR_W-1:SECT_LSB] == sect_q;
        page_hit = bus_addr[ADDR_W-1:IDX_W] == page_q;
        seq_hit  = page_hit && (bus_addr == next_q);
        count_ok = bus_data <= DATA_W'(BUF_WORDS - 1);
        home     = bypass_q ? ST_BYPASS : ST_IDLE;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (is_unlk1) state_d = ST_UNLK1;
            end
            ST_UNLK1: begin
                if (bus_we) state_d = is_unlk2 ? ST_UNLK2 : ST_IDLE;
            end
            ST_UNLK2: begin
                if (bus_we) begin
                    if (cmd == CMD_LOAD)        state_d = ST_COUNT;
                    else if (cmd == CMD_BYPASS) state_d = ST_BYPASS;
                    else if (cmd == CMD_PROG)   state_d = ST_PROG;
                    else                        state_d = ST_IDLE;
                end
            end
            ST_BYPASS: begin
                if (cmd == CMD_LOAD)       state_d = ST_COUNT;
                else if (cmd == CMD_PROG)  state_d = ST_PROG;
                else if (cmd == CMD_RESET) state_d = ST_IDLE;
            end
            ST_COUNT: begin
                if (bus_we) state_d = (sect_hit && count_ok) ? ST_LOAD_FIRST : ST_ABORT;
            end
            ST_LOAD_FIRST: begin
                if (bus_we) begin
                    if (!sect_hit)          state_d = ST_ABORT;
                    else if (remain_q == 0) state_d = ST_CONFIRM;
                    else                    state_d = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (bus_we) begin
                    if (!seq_hit)                    state_d = ST_ABORT;
                    else if (remain_q == IDX_W'(1))  state_d = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (bus_we) begin
                    if (cmd == CMD_CONFIRM && sect_hit && lock_n) state_d = ST_BUSY;
                    else                                          state_d = ST_ABORT;
                end
            end
            ST_PROG: begin
                if (bus_we) state_d = lock_n ? ST_BUSY : ST_ABORT;
            end
            ST_BUSY: begin
                if (arr_done) state_d = home;
            end
            ST_ABORT: begin
                if (!bypass_q && cmd == CMD_RESET) state_d = ST_IDLE;
                else if (is_unlk1)                 state_d = ST_ABT_U1;
            end
            ST_ABT_U1: begin
                if (bus_we) state_d = is_unlk2 ? ST_ABT_U2 : ST_ABORT;
            end
            ST_ABT_U2: begin
                if (bus_we) state_d = (cmd == CMD_RESET) ? home : ST_ABORT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // captured sequence context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sect_q   <= '0;
            page_q   <= '0;
            next_q   <= '0;
            start_q  <= '0;
            remain_q <= '0;
            last_q   <= '0;
            bypass_q <= 1'b0;
        end else if (bus_we) begin
            unique case (state_q)
                ST_UNLK2: begin
                    if (cmd == CMD_LOAD)   sect_q   <= bus_addr[ADDR_W-1:SECT_LSB];
                    if (cmd == CMD_BYPASS) bypass_q <= 1'b1;
                end
                ST_BYPASS: begin
                    if (cmd == CMD_LOAD)  sect_q   <= bus_addr[ADDR_W-1:SECT_LSB];
                    if (cmd == CMD_RESET) bypass_q <= 1'b0;
                end
                ST_COUNT: begin
                    remain_q <= bus_data[IDX_W-1:0];
                    last_q   <= bus_data[IDX_W-1:0];
                end
                ST_LOAD_FIRST: begin
                    start_q <= bus_addr;
                    page_q  <= bus_addr[ADDR_W-1:IDX_W];
                    next_q  <= bus_addr + ADDR_W'(1);
                end
                ST_LOAD: begin
                    next_q   <= next_q + ADDR_W'(1);
                    remain_q <= remain_q - IDX_W'(1);
                end
                ST_PROG: begin
                    start_q <= bus_addr;
                    last_q  <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        arr_req  = state_q == ST_BUSY;
        abort    = (state_q == ST_ABORT) || (state_q == ST_ABT_U1) || (state_q == ST_ABT_U2);
        bypass   = bypass_q;
        arr_addr = start_q;
        arr_last = last_q;
        buf_idx  = bus_addr[IDX_W-1:0];
        buf_we   = bus_we && (((state_q == ST_LOAD_FIRST) && sect_hit) ||
                              ((state_q == ST_LOAD) && seq_hit) ||
                              (state_q == ST_PROG));
    end

endmodule

// File: rtl/wbuf_cmd_seq.sv
module wbuf_cmd_seq
    import wbuf_cmd_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int BUF_WORDS = 32,
    parameter int SECT_LSB  = 15,
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              lock_n,
    input  logic              arr_done,
    input  logic [IDX_W-1:0]  arr_rd_idx,
    output logic              arr_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [IDX_W-1:0]  arr_last,
    output logic [DATA_W-1:0] arr_rd_data,
    output logic              abort,
    output logic              bypass
);

    logic             is_unlk1, is_unlk2;
    cmd_kind_e        cmd;
    logic             buf_we;
    logic [IDX_W-1:0] buf_idx;

    wbuf_cmd_decode #(.DATA_W(DATA_W)) decode_i (
        .bus_we   (bus_we),
        .cmd_addr (bus_addr[10:0]),
        .bus_data (bus_data),
        .is_unlk1 (is_unlk1),
        .is_unlk2 (is_unlk2),
        .cmd      (cmd)
    );

    wbuf_seq_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BUF_WORDS (BUF_WORDS),
        .SECT_LSB  (SECT_LSB)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_data (bus_data),
        .is_unlk1 (is_unlk1),
        .is_unlk2 (is_unlk2),
        .cmd      (cmd),
        .lock_n   (lock_n),
        .arr_done (arr_done),
        .buf_we   (buf_we),
        .buf_idx  (buf_idx),
        .arr_req  (arr_req),
        .arr_addr (arr_addr),
        .arr_last (arr_last),
        .abort    (abort),
        .bypass   (bypass)
    );

    wbuf_page_ram #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) ram_i (
        .clk     (clk),
        .wr_en   (buf_we),
        .wr_idx  (buf_idx),
        .wr_data (bus_data),
        .rd_idx  (arr_rd_idx),
        .rd_data (arr_rd_data)
    );

endmodule

// File: rtl/wbuf_cmd_seq_chk.sv
module wbuf_cmd_seq_chk #(
    parameter int ADDR_W    = 22,
    parameter int BUF_WORDS = 32,
    localparam int IDX_W    = $clog2(BUF_WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic              lock_n,
    input logic              arr_done,
    input logic              arr_req,
    input logic [ADDR_W-1:0] arr_addr,
    input logic [IDX_W-1:0]  arr_last,
    input logic              abort,
    input logic              bypass
);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_done |=> arr_req);

    assert_req_fields_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_req && !arr_done |=> $stable(arr_addr) && $stable(arr_last));

    assert_no_req_with_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(arr_req && abort));

    assert_req_needs_unlocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_req) |-> $past(lock_n));

    assert_req_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_req) |-> $past(bus_we));

    assert_abort_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        abort && !bus_we |=> abort);

    assert_bypass_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(bypass));

endmodule

bind wbuf_cmd_seq wbuf_cmd_seq_chk #(.ADDR_W(ADDR_W), .BUF_WORDS(BUF_WORDS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_we   (bus_we),
    .lock_n   (lock_n),
    .arr_done (arr_done),
    .arr_req  (arr_req),
    .arr_addr (arr_addr),
    .arr_last (arr_last),
    .abort    (abort),
    .bypass   (bypass)
);

// File: tb/wbuf_cmd_seq_tb_top.sv
module wbuf_cmd_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [21:0] SA = 22'h018000;
    localparam logic [21:0] SB = 22'h020000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [21:0] bus_addr = '0;
    logic [15:0] bus_data = '0;
    logic        lock_n = 1'b1;
    logic        arr_done = 1'b0;
    logic [4:0]  arr_rd_idx = '0;
    logic        arr_req;
    logic [21:0] arr_addr;
    logic [4:0]  arr_last;
    logic [15:0] arr_rd_data;
    logic        abort;
    logic        bypass;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wbuf_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_data(bus_data), .lock_n(lock_n), .arr_done(arr_done),
        .arr_rd_idx(arr_rd_idx), .arr_req(arr_req), .arr_addr(arr_addr),
        .arr_last(arr_last), .arr_rd_data(arr_rd_data), .abort(abort),
        .bypass(bypass)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [21:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic unlock();
        wr(22'h000555, 16'h00AA);
        wr(22'h0002AA, 16'h0055);
    endtask

    task automatic done_pulse();
        @(negedge clk); arr_done = 1'b1;
        @(negedge clk); arr_done = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int idx, input logic [15:0] exp);
        arr_rd_idx = 5'(idx);
        #1;
        chk(tag, 32'(arr_rd_data), 32'(exp));
    endtask

    task automatic t_reset();
        chk("R1 arr_req", 32'(arr_req), 0);
        chk("R1 abort", 32'(abort), 0);
        chk("R1 bypass", 32'(bypass), 0);
    endtask

    task automatic t_normal_six();
        unlock(); wr(SA, 16'h25); wr(SA, 16'h05);
        for (int i = 0; i < 6; i++) wr(SA + 22'h40 + 22'(i), 16'hA000 + 16'(i));
        chk("R2 no req before confirm", 32'(arr_req), 0);
        wr(SA, 16'h29);
        chk("R2 arr_req", 32'(arr_req), 1);
        chk("R2 arr_addr", 32'(arr_addr), 32'(SA + 22'h40));
        chk("R2 arr_last", 32'(arr_last), 5);
        for (int i = 0; i < 6; i++) rd_chk("R2 buffer word", i, 16'hA000 + 16'(i));
        repeat (3) @(negedge clk);
        chk("R6 req held", 32'(arr_req), 1);
        unlock(); wr(22'h000555, 16'h20);
        chk("R6 write while busy ignored", 32'(bypass), 0);
        chk("R6 req still held", 32'(arr_req), 1);
        done_pulse();
        chk("R6 req drops after done", 32'(arr_req), 0);
        chk("R6 no bypass after busy", 32'(bypass), 0);
        chk("R6 no abort", 32'(abort), 0);
    endtask

    task automatic t_count_limit();
        unlock(); wr(SA, 16'h25); wr(SA, 16'h20);
        chk("R3 count 20h aborts", 32'(abort), 1);
        repeat (4) @(negedge clk);
        chk("R9 abort sticky", 32'(abort), 1);
        wr(22'h0, 16'hF0);
        chk("R9 F0 clears abort", 32'(abort), 0);
        unlock(); wr(SA, 16'h25); wr(SA, 16'h1F);
        for (int i = 0; i < 32; i++) wr(SA + 22'(i), 16'h5000 + 16'(i));
        wr(SA, 16'h29);
        chk("R3 full buffer req", 32'(arr_req), 1);
        chk("R3 full buffer last", 32'(arr_last), 31);
        rd_chk("R3 word 31", 31, 16'h501F);
        rd_chk("R3 word 0", 0, 16'h5000);
        done_pulse();
    endtask

    task automatic t_order();
        unlock(); wr(SA, 16'h25); wr(SA, 16'h02);
        wr(SA + 22'h40, 16'h1); wr(SA + 22'h42, 16'h2);
        chk("R4 skipped address aborts", 32'(abort), 1);
        wr(SA, 16'h29);
        chk("R4 no req after abort", 32'(arr_req), 0);
        wr(22'h0, 16'hF0);
        unlock(); wr(SA, 16'h25); wr(SA, 16'h03);
        wr(SA + 22'h5E, 16'h1); wr(SA + 22'h5F, 16'h2);
        chk("R4 in page no abort", 32'(abort), 0);
        wr(SA + 22'h60, 16'h3);
        chk("R4 page cross aborts", 32'(abort), 1);
        wr(22'h0, 16'hF0);
    endtask

    task automatic t_sector();
        unlock(); wr(SA, 16'h25); wr(SB, 16'h00);
        chk("R5 count sector mismatch", 32'(abort), 1);
        wr(22'h0, 16'hF0);
        unlock(); wr(SA, 16'h25); wr(SA, 16'h00); wr(SB + 22'h40, 16'h7);
        chk("R5 first pair sector mismatch", 32'(abort), 1);
        wr(22'h0, 16'hF0);
        unlock(); wr(SA, 16'h25); wr(SA, 16'h00); wr(SA + 22'h40, 16'h7); wr(SA, 16'h30);
        chk("R5 bad confirm code", 32'(abort), 1);
        wr(22'h0, 16'hF0);
        unlock(); wr(SA, 16'h25); wr(SA, 16'h00); wr(SA + 22'h40, 16'h7); wr(SB, 16'h29);
        chk("R5 confirm sector mismatch", 32'(abort), 1);
        chk("R5 no req", 32'(arr_req), 0);
        wr(22'h0, 16'hF0);
    endtask

    task automatic t_lock();
        lock_n = 1'b0;
        unlock(); wr(SA, 16'h25); wr(SA, 16'h00); wr(SA + 22'h40, 16'h9); wr(SA, 16'h29);
        chk("R7 locked confirm aborts", 32'(abort), 1);
        chk("R7 locked no req", 32'(arr_req), 0);
        lock_n = 1'b1;
        wr(22'h0, 16'hF0);
        chk("R7 cleared", 32'(abort), 0);
    endtask

    task automatic t_unlock_break();
        wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0056);
        wr(SA, 16'h25); wr(SA, 16'h00); wr(SA + 22'h40, 16'h1); wr(SA, 16'h29);
        chk("R12 broken unlock no req", 32'(arr_req), 0);
        chk("R12 broken unlock no abort", 32'(abort), 0);
    endtask

    task automatic t_bypass();
        unlock(); wr(22'h000555, 16'h20);
        chk("R8 bypass set", 32'(bypass), 1);
        wr(SA + 22'h47, 16'hA0); wr(SA + 22'h47, 16'h1234);
        chk("R8 single program req", 32'(arr_req), 1);
        chk("R8 single addr", 32'(arr_addr), 32'(SA + 22'h47));
        chk("R8 single last", 32'(arr_last), 0);
        rd_chk("R8 single word", 7, 16'h1234);
        done_pulse();
        chk("R8 bypass kept", 32'(bypass), 1);
        chk("R8 req dropped", 32'(arr_req), 0);
        wr(SA, 16'h25); wr(SA, 16'h01); wr(SA + 22'h50, 16'hBEE0); wr(SA + 22'h51, 16'hBEE1);
        wr(SA, 16'h29);
        chk("R8 bypass buffer req", 32'(arr_req), 1);
        chk("R8 bypass buffer last", 32'(arr_last), 1);
        rd_chk("R8 bypass buffer word", 17, 16'hBEE1);
        done_pulse();
    endtask

    task automatic t_bypass_abort();
        wr(SA, 16'h25); wr(SA, 16'h40);
        chk("R10 bypass abort", 32'(abort), 1);
        wr(22'h0, 16'hF0);
        chk("R10 single F0 keeps abort", 32'(abort), 1);
        unlock(); wr(22'h0, 16'hF0);
        chk("R10 full reset clears", 32'(abort), 0);
        chk("R10 back in bypass", 32'(bypass), 1);
        wr(22'h0, 16'hF0);
        chk("R11 bypass exit", 32'(bypass), 0);
        wr(SA, 16'hA0); wr(SA, 16'h5555);
        chk("R11 program without unlock ignored", 32'(arr_req), 0);
        chk("R11 no abort", 32'(abort), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_six();
        t_count_limit();
        t_order();
        t_sector();
        t_lock();
        t_unlock_break();
        t_bypass();
        t_bypass_abort();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule